// File: doc/BRIEF.md
# Dual-Channel Pulse-Width Modulator with Table Prescaler

This block generates two independent pulse-width modulated outputs from a single source clock. Software programs it through a small 32-bit register space written with a plain write strobe and read combinationally by address. A shared control word holds one configuration field per channel. Each channel also has its own period/duty word, and a new value written there is held pending until the running period ends.

Each channel divides the source clock by a value chosen from a fixed table of dividers. It counts prescaled ticks through a period of programmable length and drives its output to the active level while the count is below the duty value. Software sets the polarity, a one-shot pulse option and a bypass option. Bypass routes the raw source clock straight to the pin and overrides every other setting.

Top module: `pwm_dual_ctrl`

## Requirements
- R1: Offset 0 is the control word. Channel n's 10-bit field sits at bits [15n+9:15n]: prescaler code in [3:0], enable in bit 4, active level in bit 5, clock gate in bit 6, mode in bit 7, pulse in bit 8, bypass in bit 9. All of these read back as written. Bit 28+n reads as channel n's ready flag, and every other bit reads 0. Offset 4+4n is channel n's period/duty word: period ticks minus one in [31:16], duty ticks in [15:0]. It reads back the last value written.
- R2: A channel's counter runs only while both its enable and clock-gate bits are 1. Otherwise the counter is cleared and the output holds the inactive level. After reset every output is 1, because the active-level bit resets to 0.
- R3: With the active-level bit at 1 the output is high for the duty portion and low otherwise. With it at 0 the waveform is inverted.
- R4: A period lasts (period field + 1) prescaled ticks, and the output is active for the first `duty` ticks of each period.
- R5: A duty of 0 gives a constant inactive output. A duty at or above period field + 1 gives a constant active output.
- R6: Prescaler codes 0,1,2,3,4 divide by 120,180,240,360,480. Codes 8,9,10,11,12 divide by 12000,24000,36000,48000,72000. Code 15 divides by 1.
- R7: Codes 5, 6, 7, 13 and 14 are reserved. With a reserved code the channel counter is stopped and cleared, and the output holds the inactive level.
- R8: With the bypass bit set, the channel output equals the source clock, whatever the enable, gate, prescaler and period settings are.
- R9: Writing a period/duty word drops that channel's ready flag to 0. While the channel runs, the value loads at the end of the current period. While it is stopped, it loads on the next cycle. The flag returns to 1 once the load is done.
- R10: With both the mode and pulse bits set, a channel emits exactly one period and then holds the inactive level until its enable or gate is cleared or pulse mode is left.
- R11: The channels are independent. Each one's waveform depends only on its own field and its own period/duty word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock; also the bypass output source |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, sampled on the rising clock edge |
| addr | input | 4 | Byte offset of the register accessed |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| pwm_out | output | 2 | Channel outputs, bit n for channel n |

## Verification
The assertions check, on every cycle, the rules that govern the counter and the loading of pending values. The count never passes the loaded period. A stopped channel clears its count and drives its inactive level. A write always raises the pending state, and a stopped channel loads a pending value one cycle later. A zero duty never produces an active output. The behaviours that span many cycles can only be shown by the bench scenarios: duty ratios, prescaler ratios, one-shot length, the deferred load while a channel runs, the clock passed through in bypass, and the register read-back layout. The bench measures these by counting active cycles over windows that are whole multiples of the period.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    localparam int CFG_W        = 10;
    localparam int FIELD_STRIDE = 15;
    localparam int RDY_BASE     = 28;
    localparam int DIV_W        = 17;

    // Per-channel control field, bit 9 down to bit 0
    typedef struct packed {
        logic       bypass;
        logic       pulse;
        logic       mode;
        logic       gate;
        logic       act;
        logic       en;
        logic [3:0] code;
    } chan_cfg_t;

    // Divider for a prescaler code; zero marks a reserved code
    function automatic logic [DIV_W-1:0] presc_div(input logic [3:0] code);
        case (code)
            4'd0:    return DIV_W'(120);
            4'd1:    return DIV_W'(180);
            4'd2:    return DIV_W'(240);
            4'd3:    return DIV_W'(360);
            4'd4:    return DIV_W'(480);
            4'd8:    return DIV_W'(12000);
            4'd9:    return DIV_W'(24000);
            4'd10:   return DIV_W'(36000);
            4'd11:   return DIV_W'(48000);
            4'd12:   return DIV_W'(72000);
            4'd15:   return DIV_W'(1);
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
    import pwm_pkg::*;
#(
    parameter int DW = DIV_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [DW-1:0] div,
    output logic          tick
);

    logic [DW-1:0] pcnt_d, pcnt_q;

    always_comb begin
        tick   = run && (pcnt_q == div - 1'b1);
        pcnt_d = pcnt_q;
        if (!run || tick) begin
            pcnt_d = '0;
        end else begin
            pcnt_d = pcnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pcnt_q <= '0;
        end else begin
            pcnt_q <= pcnt_d;
        end
    end

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
    import pwm_pkg::*;
#(
    parameter int CNT_W = 16,
    localparam int WORD_W = 2 * CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  chan_cfg_t         cfg,
    input  logic              wr_prd,
    input  logic [WORD_W-1:0] wdata,
    output logic              shaped,
    output logic              pending,
    output logic [WORD_W-1:0] shadow_rd,
    output logic              run_o,
    output logic [CNT_W-1:0]  cnt_o,
    output logic [CNT_W-1:0]  prd_o,
    output logic [CNT_W-1:0]  duty_o
);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [CNT_W-1:0]  prd;
        logic [CNT_W-1:0]  duty;
        logic [WORD_W-1:0] shadow;
        logic              pend;
        logic              done;
        logic              out;
    } ch_state_t;

    ch_state_t        s_d, s_q;
    logic [DIV_W-1:0] div;
    logic             code_ok;
    logic             run;
    logic             tick;
    logic             at_end;
    logic             pulse_mode;

    assign div        = presc_div(cfg.code);
    assign code_ok    = (div != '0);
    assign run        = cfg.en && cfg.gate && code_ok && !cfg.bypass && !s_q.done;
    assign pulse_mode = cfg.mode && cfg.pulse;
    assign at_end     = (s_q.cnt == s_q.prd);

    pwm_prescaler #(.DW(DIV_W)) u_presc (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (run),
        .div  (div),
        .tick (tick)
    );

    always_comb begin
        s_d = s_q;

        // period counter
        if (!run) begin
            s_d.cnt = '0;
        end else if (tick) begin
            s_d.cnt = at_end ? '0 : s_q.cnt + 1'b1;
        end

        // pending value loads at a period boundary, or at once when stopped
        if (s_q.pend && (!run || (tick && at_end))) begin
            s_d.prd  = s_q.shadow[WORD_W-1:CNT_W];
            s_d.duty = s_q.shadow[CNT_W-1:0];
            s_d.pend = 1'b0;
        end
        if (wr_prd) begin
            s_d.shadow = wdata;
            s_d.pend   = 1'b1;
        end

        // one-shot completion
        if (!(cfg.en && cfg.gate) || !pulse_mode) begin
            s_d.done = 1'b0;
        end else if (run && tick && at_end) begin
            s_d.done = 1'b1;
        end

        // output shaping
        s_d.out = (run && (s_q.cnt < s_q.duty)) ? cfg.act : !cfg.act;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q     <= '0;
            s_q.out <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign shaped    = s_q.out;
    assign pending   = s_q.pend;
    assign shadow_rd = s_q.shadow;
    assign run_o     = run;
    assign cnt_o     = s_q.cnt;
    assign prd_o     = s_q.prd;
    assign duty_o    = s_q.duty;

endmodule

// File: rtl/pwm_dual_ctrl.sv
module pwm_dual_ctrl
    import pwm_pkg::*;
#(
    parameter int NCH    = 2,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [NCH-1:0]    pwm_out
);

    localparam int CNT_W = DATA_W / 2;

    chan_cfg_t [NCH-1:0]             cfg_d, cfg_q;
    logic      [NCH-1:0]             ch_wr;
    logic      [NCH-1:0]             ch_shaped;
    logic      [NCH-1:0]             ch_pend;
    logic      [NCH-1:0]             ch_run;
    logic      [NCH-1:0]             ch_act;
    logic      [NCH-1:0][DATA_W-1:0] ch_shadow;
    logic      [NCH-1:0][CNT_W-1:0]  ch_cnt;
    logic      [NCH-1:0][CNT_W-1:0]  ch_prd;
    logic      [NCH-1:0][CNT_W-1:0]  ch_duty;

    // control word: next value and per-channel write strobes
    always_comb begin
        cfg_d = cfg_q;
        ch_wr = '0;
        for (int ch = 0; ch < NCH; ch++) begin
            if (wr_en && addr == '0) begin
                cfg_d[ch] = chan_cfg_t'(wdata[ch*FIELD_STRIDE +: CFG_W]);
            end
            ch_wr[ch] = wr_en && (addr == ADDR_W'((ch + 1) * 4));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_ch
            pwm_channel #(.CNT_W(CNT_W)) u_ch (
                .clk      (clk),
                .rst_n    (rst_n),
                .cfg      (cfg_q[g]),
                .wr_prd   (ch_wr[g]),
                .wdata    (wdata),
                .shaped   (ch_shaped[g]),
                .pending  (ch_pend[g]),
                .shadow_rd(ch_shadow[g]),
                .run_o    (ch_run[g]),
                .cnt_o    (ch_cnt[g]),
                .prd_o    (ch_prd[g]),
                .duty_o   (ch_duty[g])
            );
            assign ch_act[g]  = cfg_q[g].act;
            assign pwm_out[g] = cfg_q[g].bypass ? clk : ch_shaped[g];
        end
    endgenerate

    // read mux
    always_comb begin
        rdata = '0;
        if (addr == '0) begin
            for (int ch = 0; ch < NCH; ch++) begin
                rdata[ch*FIELD_STRIDE +: CFG_W] = cfg_q[ch];
                rdata[RDY_BASE + ch]            = !ch_pend[ch];
            end
        end else begin
            for (int ch = 0; ch < NCH; ch++) begin
                if (addr == ADDR_W'((ch + 1) * 4)) begin
                    rdata = ch_shadow[ch];
                end
            end
        end
    end

endmodule

// File: rtl/pwm_dual_ctrl_chk.sv
module pwm_dual_ctrl_chk #(
    parameter int NCH   = 2,
    parameter int CNT_W = 16
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [NCH-1:0]             run,
    input logic [NCH-1:0]             wr_prd,
    input logic [NCH-1:0]             pend,
    input logic [NCH-1:0]             shaped,
    input logic [NCH-1:0]             act,
    input logic [NCH-1:0][CNT_W-1:0]  cnt,
    input logic [NCH-1:0][CNT_W-1:0]  prd,
    input logic [NCH-1:0][CNT_W-1:0]  duty
);

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_chk
            // R4
            cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
                cnt[g] <= prd[g]);

            // R7
            stopped_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !run[g] |=> (cnt[g] == '0));

            // R9
            write_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
                wr_prd[g] |=> pend[g]);

            // R9
            idle_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (pend[g] && !run[g] && !wr_prd[g]) |=> !pend[g]);

            // R2
            idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !run[g] |=> (shaped[g] == !$past(act[g])));

            // R5
            zero_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (run[g] && duty[g] == '0) |=> (shaped[g] == !$past(act[g])));
        end
    endgenerate

endmodule

bind pwm_dual_ctrl pwm_dual_ctrl_chk #(.NCH(NCH), .CNT_W(CNT_W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (ch_run),
    .wr_prd(ch_wr),
    .pend  (ch_pend),
    .shaped(ch_shaped),
    .act   (ch_act),
    .cnt   (ch_cnt),
    .prd   (ch_prd),
    .duty  (ch_duty)
);

// File: tb/tb_pwm_dual_ctrl.sv
module tb_pwm_dual_ctrl;

    localparam int CLK_P = 10;

    localparam logic [9:0] F_EN    = 10'h010;
    localparam logic [9:0] F_ACT   = 10'h020;
    localparam logic [9:0] F_GATE  = 10'h040;
    localparam logic [9:0] F_MODE  = 10'h080;
    localparam logic [9:0] F_PULSE = 10'h100;
    localparam logic [9:0] F_BYP   = 10'h200;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [1:0]  pwm_out;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;
    logic [31:0] ctrl_img = '0;

    always #(CLK_P/2) clk = ~clk;

    pwm_dual_ctrl dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .addr   (addr),
        .wdata  (wdata),
        .rdata  (rdata),
        .pwm_out(pwm_out)
    );

    task automatic check_eq(input string req, input string what,
                            input longint actual, input longint expected);
        n_checks++;
        if (actual != expected) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, actual, expected);
        end
    endtask

    task automatic do_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        addr  = a;
        wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_read(input logic [3:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic count_high(input int ch, input int n, output int k);
        k = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm_out[ch]) k++;
        end
    endtask

    task automatic set_field(input int ch, input logic [9:0] f);
        ctrl_img[ch*15 +: 10] = f;
        do_write(4'd0, ctrl_img);
    endtask

    // stop channel, load period/duty, start with the given field
    task automatic set_ch(input int ch, input logic [9:0] f, input logic [15:0] prd,
                          input logic [15:0] duty, input int settle);
        set_field(ch, f & F_ACT);
        do_write(4'((ch + 1) * 4), {prd, duty});
        repeat (2) @(negedge clk);
        set_field(ch, f);
        repeat (settle) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        do_read(4'd0, d);
        check_eq("R1", "ctrl after reset", d, 32'h3000_0000);
        do_read(4'd4, d);
        check_eq("R1", "ch0 word after reset", d, 0);
        do_read(4'd8, d);
        check_eq("R1", "ch1 word after reset", d, 0);
        check_eq("R2", "outputs after reset", pwm_out, 2'b11);
    endtask

    task automatic t_regmap();
        logic [31:0] d;
        do_write(4'd0, 32'h8000_1000 | (32'h2C3 << 15) | 32'h1A5);
        do_read(4'd0, d);
        check_eq("R1", "ctrl readback", d, 32'h3161_81A5);
        do_write(4'd0, 32'h0);
        ctrl_img = '0;
        do_write(4'd8, 32'h1234_5678);
        do_read(4'd8, d);
        check_eq("R1", "ch1 word readback", d, 32'h1234_5678);
        do_read(4'd4, d);
        check_eq("R11", "ch0 word untouched by ch1 write", d, 0);
    endtask

    task automatic t_duty();
        int k;
        set_ch(0, F_EN | F_GATE | F_ACT | 10'hF, 16'd9, 16'd3, 4);
        count_high(0, 100, k);
        check_eq("R4", "duty 3 of 10 high count", k, 30);
        set_ch(0, F_EN | F_GATE | 10'hF, 16'd9, 16'd3, 4);
        count_high(0, 100, k);
        check_eq("R3", "inverted duty 3 of 10 high count", k, 70);
    endtask

    task automatic t_gate();
        int k;
        set_ch(0, F_EN | F_ACT | 10'hF, 16'd9, 16'd5, 4);
        count_high(0, 100, k);
        check_eq("R2", "enable without gate", k, 0);
        set_ch(0, F_GATE | F_ACT | 10'hF, 16'd9, 16'd5, 4);
        count_high(0, 100, k);
        check_eq("R2", "gate without enable", k, 0);
    endtask

    task automatic t_extremes();
        int k;
        set_ch(0, F_EN | F_GATE | F_ACT | 10'hF, 16'd9, 16'd0, 4);
        count_high(0, 100, k);
        check_eq("R5", "zero duty", k, 0);
        set_ch(0, F_EN | F_GATE | F_ACT | 10'hF, 16'd9, 16'd10, 4);
        count_high(0, 100, k);
        check_eq("R5", "duty equal to period", k, 100);
        set_ch(0, F_EN | F_GATE | F_ACT | 10'hF, 16'd9, 16'd500, 4);
        count_high(0, 100, k);
        check_eq("R5", "duty above period", k, 100);
    endtask

    task automatic t_prescale();
        int k;
        set_ch(0, F_EN | F_GATE | F_ACT | 10'h0, 16'd1, 16'd1, 4);
        count_high(0, 480, k);
        check_eq("R6", "code 0 divide by 120", k, 240);
        set_ch(0, F_EN | F_GATE | F_ACT | 10'h4, 16'd1, 16'd1, 4);
        count_high(0, 1920, k);
        check_eq("R6", "code 4 divide by 480", k, 960);
        set_ch(0, F_EN | F_GATE | F_ACT | 10'h8, 16'd1, 16'd1, 4);
        count_high(0, 24000, k);
        check_eq("R6", "code 8 divide by 12000", k, 12000);
    endtask

    task automatic t_reserved();
        int k;
        set_ch(0, F_EN | F_GATE | F_ACT | 10'hD, 16'd1, 16'd1, 4);
        count_high(0, 300, k);
        check_eq("R7", "reserved code 13 output", k, 0);
        set_ch(0, F_EN | F_GATE | 10'h6, 16'd1, 16'd1, 4);
        count_high(0, 300, k);
        check_eq("R7", "reserved code 6 inverted output", k, 300);
    endtask

    task automatic t_bypass();
        int bad = 0;
        set_ch(0, F_BYP, 16'd9, 16'd3, 2);
        for (int i = 0; i < 8; i++) begin
            @(posedge clk); #1;
            if (pwm_out[0] !== 1'b1) bad++;
            @(negedge clk); #1;
            if (pwm_out[0] !== 1'b0) bad++;
        end
        check_eq("R8", "bypass follows clock, disabled", bad, 0);
        bad = 0;
        set_ch(0, F_BYP | F_EN | F_GATE | 10'h6, 16'd9, 16'd0, 2);
        for (int i = 0; i < 8; i++) begin
            @(posedge clk); #1;
            if (pwm_out[0] !== 1'b1) bad++;
            @(negedge clk); #1;
            if (pwm_out[0] !== 1'b0) bad++;
        end
        check_eq("R8", "bypass follows clock, other bits set", bad, 0);
    endtask

    task automatic t_ready();
        logic [31:0] d;
        int k;
        int waited = 0;
        set_ch(0, 10'h0, 16'd9, 16'd3, 0);
        do_write(4'd4, {16'd9, 16'd7});
        @(negedge clk);
        do_read(4'd0, d);
        check_eq("R9", "ready after write to stopped channel", d[28], 1);
        set_ch(0, F_EN | F_GATE | F_ACT | 10'h0, 16'd9, 16'd3, 4);
        do_write(4'd4, {16'd9, 16'd7});
        do_read(4'd0, d);
        check_eq("R9", "ready low while running value pending", d[28], 0);
        do begin
            @(negedge clk);
            waited++;
            do_read(4'd0, d);
        end while (d[28] == 1'b0 && waited < 1500);
        check_eq("R9", "ready returns at period boundary", d[28], 1);
        repeat (4) @(negedge clk);
        count_high(0, 2400, k);
        check_eq("R9", "new duty active after load", k, 1680);
    endtask

    task automatic t_pulse();
        int k;
        set_ch(0, F_EN | F_GATE | F_ACT | F_MODE | F_PULSE | 10'hF, 16'd9, 16'd5, 0);
        count_high(0, 100, k);
        check_eq("R10", "one-shot active cycles", k, 5);
        count_high(0, 100, k);
        check_eq("R10", "idle after one-shot", k, 0);
    endtask

    task automatic t_indep();
        int k0;
        int k1;
        set_ch(0, F_EN | F_GATE | F_ACT | 10'hF, 16'd9, 16'd3, 0);
        set_ch(1, F_EN | F_GATE | F_ACT | 10'hF, 16'd4, 16'd2, 4);
        count_high(1, 100, k1);
        count_high(0, 100, k0);
        check_eq("R11", "ch1 duty 2 of 5", k1, 40);
        check_eq("R11", "ch0 unchanged by ch1", k0, 30);
    endtask

    initial begin
        #(CLK_P * 190000);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regmap();
        t_duty();
        t_gate();
        t_extremes();
        t_prescale();
        t_reserved();
        t_bypass();
        t_ready();
        t_pulse();
        t_indep();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule